// File: doc/BRIEF.md
# Self-Aligning Byte Serializer

This block turns 8-bit parallel bytes into a serial bit stream, one bit per cycle of a single high-speed bit clock. The upstream byte clock reaches the block as a one-cycle strobe, `byte_stb`, sampled on the bit clock. Its phase has no fixed relation to the block's own divide-by-8 phase counter. On each strobe the byte on `byte_in` is captured into an input register. When the internal phase counter reaches its transfer phase, the captured byte moves into a shift register, which sends it out least significant bit first.

The internal phase counter drives a phase-adjustable byte clock, `adj_bclk`. A second divide-by-8 counter drives `ref_bclk`, which never moves and so can serve as a system reference. `phase_err` reports when the strobe lands too close to the internal transfer phase. A rising edge on `sync_req` arms a realignment. On the next strobe the internal phase is reloaded so that the transfer falls four bit times after that strobe. `phase_err` may be wired straight to `sync_req` so that the block aligns itself.

The alignment controller has three states:
- `ST_LOCKED`: normal operation.
- `ST_ARMED`: a sync edge has been seen and the block waits for a strobe.
- `ST_SLIP`: the phase has just been reloaded, and the serial output is held low until the next transfer.

The transitions are:
- LOCKED→ARMED on a sync rising edge.
- ARMED→SLIP on a strobe, which also reloads the phase.
- SLIP→LOCKED at the next transfer.

Top module: `byte_serializer_align`

## Requirements
- R1: While reset is asserted, both phase counters sit at phase 0, so `adj_bclk` and `ref_bclk` are both 1. `phase_err` is 0 and `ser_out` is 0.
- R2: `ref_bclk` is 1 during reference phases 0 to 3 and 0 during phases 4 to 7. Its phase counter advances by one every cycle and is never altered by `sync_req`.
- R3: `adj_bclk` is 1 during internal phases 0 to 3 and 0 during phases 4 to 7. The internal counter advances by one every cycle except when it is reloaded.
- R4: A strobe captures `byte_in` into the input register. In the cycle where the internal phase is 7, the input register is loaded into the shift register. `ser_out` then carries bit 0 at internal phase 0, bit 1 at phase 1, and so on up to bit 7 at phase 7. Bits shifted beyond the byte are 0, and `ser_out` is 0 after reset until the first transfer.
- R5: `phase_err` changes only at a strobe. It becomes 1 when the strobe falls at internal phase 6, 7 or 0, and becomes 0 when the strobe falls at any other phase.
- R6: Only a 0→1 change of `sync_req` arms a realignment. A level held high does not arm again, and edges in the armed or slip states are ignored. A sync edge in the same cycle as a strobe arms the block but does not realign at that strobe.
- R7: At the first strobe after arming, the internal phase is reloaded to 4 in the next cycle, so the next transfer occurs four cycles after that strobe.
- R8: From the reload until that next transfer, `ser_out` is 0. The byte in flight is dropped, and the byte captured by the realigning strobe is the first one sent afterwards.
- R9: With `phase_err` fed to `sync_req`, a misaligned strobe leads to one realignment. After it, the strobes land at internal phase 3 and `phase_err` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_stb | input | 1 | External byte clock strobe, one cycle per byte |
| byte_in | input | 8 | Parallel byte, bit 0 sent first |
| sync_req | input | 1 | Realignment request, rising-edge sensitive |
| ser_out | output | 1 | Serial data |
| adj_bclk | output | 1 | Phase-adjustable byte clock |
| ref_bclk | output | 1 | Fixed-phase reference byte clock |
| phase_err | output | 1 | Strobe within one bit of the transfer phase |

## Verification
Two cases are driven on purpose:
- A sync rising edge in the same cycle as a strobe. The sync edge must win as arming only, and the realignment must wait for the following strobe.
- A strobe at the transfer phase itself, so that capture and transfer fall in the same cycle. The old input register must be transferred while the new byte is captured.

A cycle-level reference model in the bench predicts every serial bit, both byte clocks and the error flag. The bench also checks the final phase relation between `adj_bclk` and `ref_bclk` after a manual realignment and after a feedback realignment.

// File: rtl/bser_pkg.sv
package bser_pkg;
    typedef enum logic [1:0] {
        ST_LOCKED = 2'd0,
        ST_ARMED  = 2'd1,
        ST_SLIP   = 2'd2
    } align_st_e;
endpackage

// File: rtl/bser_phase_ctr.sv
module bser_phase_ctr #(
    parameter int W = 3,
    parameter logic [W-1:0] LOAD_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    output logic [W-1:0] cnt,
    output logic         bclk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else
            cnt <= cnt + 1'b1;
    end

    // high during the first half of the byte period
    assign bclk = ~cnt[W-1];
endmodule

// File: rtl/bser_align_fsm.sv
module bser_align_fsm
    import bser_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sync_req,
    input  logic      byte_stb,
    input  logic      xfer,
    output logic      reload,
    output logic      blank,
    output align_st_e st
);
    align_st_e st_nx;
    logic      sync_q;
    logic      sync_rise;

    assign sync_rise = sync_req & ~sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_LOCKED;
            sync_q <= 1'b0;
        end else begin
            st     <= st_nx;
            sync_q <= sync_req;
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOCKED: if (sync_rise) st_nx = ST_ARMED;
            ST_ARMED:  if (byte_stb)  st_nx = ST_SLIP;
            ST_SLIP:   if (xfer)      st_nx = ST_LOCKED;
            default:                  st_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        reload = 1'b0;
        blank  = 1'b0;
        unique case (st)
            ST_LOCKED: ;
            ST_ARMED:  reload = byte_stb;
            ST_SLIP:   blank  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/bser_shift_path.sv
module bser_shift_path #(
    parameter int LANES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_stb,
    input  logic [LANES-1:0] byte_in,
    input  logic             xfer,
    input  logic             blank,
    output logic             ser_out
);
    logic [LANES-1:0] in_q;
    logic [LANES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= '0;
            sh_q <= '0;
        end else begin
            if (byte_stb)
                in_q <= byte_in;
            if (xfer)
                sh_q <= in_q;
            else
                sh_q <= {1'b0, sh_q[LANES-1:1]};
        end
    end

    assign ser_out = blank ? 1'b0 : sh_q[0];
endmodule

// File: rtl/byte_serializer_align.sv
module byte_serializer_align
    import bser_pkg::*;
#(
    parameter int LANES = 8,
    parameter int LEAD  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_stb,
    input  logic [LANES-1:0] byte_in,
    input  logic             sync_req,
    output logic             ser_out,
    output logic             adj_bclk,
    output logic             ref_bclk,
    output logic             phase_err
);
    localparam int PH_W = $clog2(LANES);
    localparam logic [PH_W-1:0] XFER_PH   = PH_W'(LANES - 1);
    localparam logic [PH_W-1:0] EARLY_PH  = PH_W'(LANES - 2);
    localparam logic [PH_W-1:0] RELOAD_PH = PH_W'(LANES - LEAD);

    logic [PH_W-1:0] adj_cnt;
    logic [PH_W-1:0] ref_cnt;
    logic            xfer;
    logic            near;
    logic            reload;
    logic            blank;
    align_st_e       align_st;

    bser_phase_ctr #(.W(PH_W), .LOAD_VAL(RELOAD_PH)) i_adj_ctr (
        .clk(clk), .rst_n(rst_n), .load(reload), .cnt(adj_cnt), .bclk(adj_bclk)
    );

    bser_phase_ctr #(.W(PH_W), .LOAD_VAL('0)) i_ref_ctr (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .cnt(ref_cnt), .bclk(ref_bclk)
    );

    bser_align_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .byte_stb(byte_stb),
        .xfer(xfer), .reload(reload), .blank(blank), .st(align_st)
    );

    bser_shift_path #(.LANES(LANES)) i_path (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_in(byte_in),
        .xfer(xfer), .blank(blank), .ser_out(ser_out)
    );

    assign xfer = (adj_cnt == XFER_PH);
    // capture window: one bit time either side of the transfer phase
    assign near = (adj_cnt == EARLY_PH) || (adj_cnt == XFER_PH) || (adj_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_err <= 1'b0;
        else if (byte_stb)
            phase_err <= near;
    end
endmodule

// File: rtl/bser_align_chk.sv
module bser_align_chk
    import bser_pkg::*;
#(
    parameter int LANES = 8,
    parameter int LEAD  = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     byte_stb,
    input logic                     sync_req,
    input logic                     ser_out,
    input logic                     ref_bclk,
    input logic                     phase_err,
    input align_st_e                st,
    input logic [$clog2(LANES)-1:0] adj_cnt,
    input logic [$clog2(LANES)-1:0] ref_cnt
);
    localparam int PH_W = $clog2(LANES);
    localparam logic [PH_W-1:0] XFER_PH   = PH_W'(LANES - 1);
    localparam logic [PH_W-1:0] FAR_PH    = PH_W'(LANES / 2 - 1);
    localparam logic [PH_W-1:0] RELOAD_PH = PH_W'(LANES - LEAD);

    AST_REF_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_bclk) |-> !$past(ref_bclk, 4) && $past(ref_bclk, 5)); // R2
    AST_REF_IGNORES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> ref_cnt == $past(ref_cnt) + 1'b1); // R2
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(phase_err)); // R5
    AST_ERR_AT_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && adj_cnt == XFER_PH) |=> phase_err); // R5
    AST_ERR_CLEAR_FAR: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && adj_cnt == FAR_PH) |=> !phase_err); // R5
    AST_RELOAD_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && byte_stb) |=> adj_cnt == RELOAD_PH); // R7
    AST_SLIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ARMED && byte_stb) |=> !ser_out); // R8
endmodule

bind byte_serializer_align bser_align_chk #(.LANES(LANES), .LEAD(LEAD)) u_chk (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .sync_req(sync_req),
    .ser_out(ser_out), .ref_bclk(ref_bclk), .phase_err(phase_err),
    .st(align_st), .adj_cnt(adj_cnt), .ref_cnt(ref_cnt)
);

// File: tb/test_byte_serializer_align.sv
module test_byte_serializer_align;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb = 1'b0;
    logic [7:0] din = 8'h00;
    logic       sync_drv = 1'b0;
    logic       loop_en = 1'b0;
    logic       sync_in;
    logic       ser_out, adj_bclk, ref_bclk, phase_err;

    always #10 clk = ~clk;  // 50 MHz

    assign sync_in = loop_en ? phase_err : sync_drv;

    byte_serializer_align i_byte_serializer_align (
        .clk(clk), .rst_n(rst_n), .byte_stb(stb), .byte_in(din),
        .sync_req(sync_in), .ser_out(ser_out), .adj_bclk(adj_bclk),
        .ref_bclk(ref_bclk), .phase_err(phase_err)
    );

    typedef struct packed { logic ser; logic adj; logic rf; logic err; } exp_t;
    exp_t sb_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int byte_idx = 0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model built from the requirements
    int         m_ph, r_ph, m_st;   // m_st: 0 locked, 1 armed, 2 slip
    logic [7:0] m_in, m_sh;
    logic       m_err, m_sq, mv_s;
    bit         mv_rise, mv_xf, mv_rl;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; r_ph = 0; m_st = 0; m_in = 0; m_sh = 0; m_err = 0; m_sq = 0;
            sb_q.delete();
        end else begin
            mv_s    = loop_en ? m_err : sync_drv;
            mv_rise = mv_s && !m_sq;
            mv_xf   = (m_ph == 7);
            mv_rl   = (m_st == 1) && stb;
            if (stb) m_err = (m_ph == 6) || (m_ph == 7) || (m_ph == 0);
            case (m_st)
                0: if (mv_rise) m_st = 1;
                1: if (stb) m_st = 2;
                default: if (mv_xf) m_st = 0;
            endcase
            m_sh = mv_xf ? m_in : (m_sh >> 1);
            if (stb) m_in = din;
            m_ph = mv_rl ? 4 : (m_ph + 1) % 8;
            r_ph = (r_ph + 1) % 8;
            m_sq = mv_s;
            sb_q.push_back({(m_st == 2) ? 1'b0 : m_sh[0], m_ph < 4, r_ph < 4, m_err});
        end
    end

    // monitor: pops expectations and compares mid-cycle
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk("R4 R8 ser_out", {7'd0, ser_out},  {7'd0, e.ser});
            chk("R3 adj_bclk",   {7'd0, adj_bclk}, {7'd0, e.adj});
            chk("R2 ref_bclk",   {7'd0, ref_bclk}, {7'd0, e.rf});
            chk("R5 phase_err",  {7'd0, phase_err},{7'd0, e.err});
        end
    end

    // driver: strobe at reference phase 'off'; sync rises with byte 'sync_at' and is held
    task automatic drive_bytes(input int n, input int off, input int sync_at);
        int sent = 0;
        while (sent < n) begin
            @(negedge clk);
            if (r_ph == off) begin
                stb = 1'b1;
                din = 8'(8'h3C + byte_idx * 29);
                if (sent == sync_at) sync_drv = 1'b1;
                byte_idx++;
                sent++;
            end else begin
                stb = 1'b0;
            end
        end
        @(negedge clk);
        stb = 1'b0;
        repeat (10) @(negedge clk);
        sync_drv = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ser_out",   {7'd0, ser_out},   8'd0);
        chk("R1 phase_err", {7'd0, phase_err}, 8'd0);
        chk("R1 adj_bclk",  {7'd0, adj_bclk},  8'd1);
        chk("R1 ref_bclk",  {7'd0, ref_bclk},  8'd1);
        rst_n = 1'b1;

        // aligned strobes: far from transfer phase
        drive_bytes(6, 3, -1);
        chk("R5 no error when strobe far", {7'd0, phase_err}, 8'd0);

        // strobe at transfer phase: capture and transfer in one cycle
        drive_bytes(6, 7, -1);
        chk("R5 error when strobe at transfer", {7'd0, phase_err}, 8'd1);

        // sync rises with a strobe, held high: one realignment only
        drive_bytes(6, 7, 1);
        chk("R7 error cleared after realign", {7'd0, phase_err}, 8'd0);
        chk("R6 single shift: adj opposite ref", {7'd0, adj_bclk}, {7'd0, ~ref_bclk});

        // error fed back to sync
        loop_en = 1'b1;
        drive_bytes(8, 3, -1);
        chk("R9 error cleared by feedback", {7'd0, phase_err}, 8'd0);
        chk("R9 adj back in phase with ref", {7'd0, adj_bclk}, {7'd0, ref_bclk});
        loop_en = 1'b0;

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule